// File: doc/BRIEF.md
# Data Access Alignment Fault Checker

This block sits beside the load/store path of the most privileged execution level and decides whether a data access has to be stopped for misalignment. Each access arrives with its byte address and its size, given as log2 of the byte count. Three flags come with it: the stack pointer is the base register, the access belongs to the atomic/ordered class that must stay inside one 16-byte block, or it belongs to the class that is checked whatever the global setting.

Three static configuration inputs select the checks. The first enables element-size alignment checking. The second enables checking the stack-pointer base for 16-byte alignment. The third allows accesses of the window class to cross a 16-byte block without a fault. Three independent tests run on every access. Their outcome is reduced to one fault code, which is registered and presented one cycle after the access strobe.

Top module: `align_fault_chk`

## Requirements
- R1: With the alignment enable at 1, an access whose address is not a multiple of its byte count reports fault type 01 (alignment).
- R2: With the alignment enable at 0, an access flagged as always-checked is still checked for element-size alignment and reports 01 when misaligned.
- R3: With the alignment enable at 0, a misaligned access that is neither always-checked nor of the window class reports no fault (type 00).
- R4: With the stack-alignment enable at 1 and the stack-pointer-base flag at 1, a base address whose low four bits are not zero reports fault type 10 (stack-pointer alignment).
- R5: The stack-pointer check reports nothing when the stack-alignment enable is 0 or when the stack-pointer-base flag is 0.
- R6: For a window-class access with the non-aligned-allowed input at 0, the access reports fault type 01 when (address mod 16) plus its byte count exceeds 16. It reports no fault when the access ends exactly at the block boundary.
- R7: With the non-aligned-allowed input at 1, a window-class access that crosses a 16-byte block does not fault through the window rule.
- R8: When the stack-pointer fault and an alignment fault both apply to one access, the reported type is 10.
- R9: The fault valid output rises exactly one cycle after an accepted access that faults and at no other time. The fault type is 00 whenever fault valid is 0 and is never 11.
- R10: Size codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are treated as 16 bytes.
- R11: While reset is asserted, fault valid is 0 and the fault type is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_lgsz | input | SZ_W | log2 of the access byte count |
| acc_sp_base | input | 1 | Base register is the stack pointer |
| acc_win_cls | input | 1 | Access uses the 16-byte window rule |
| acc_strict | input | 1 | Access is always alignment checked |
| cfg_align_en | input | 1 | Element-size alignment check enable |
| cfg_sp_align_en | input | 1 | Stack-pointer 16-byte alignment check enable |
| cfg_unaligned_ok | input | 1 | Window-class crossing is allowed |
| flt_vld | output | 1 | Fault reported for the access of the previous cycle |
| flt_type | output | 2 | 00 none, 01 alignment, 10 stack-pointer alignment |

## Verification
The hardest case to reach is an access that meets more than one rule at once. Two examples are a stack-pointer-based access that is also element-misaligned, and a window-class access that is misaligned as an element but does not cross its block while crossing is allowed. The bench reaches these by setting the configuration inputs before directed accesses that target each overlap. It then sweeps every offset within a block against every size, with crossing allowed and with it forbidden. Accesses are also issued back to back, so that the one-cycle report of one access cannot be confused with the report of its neighbour.

// File: rtl/align_fault_chk.sv
module align_fault_chk #(
  parameter int ADDR_W = 48,
  parameter int SZ_W   = 3,
  parameter int WIN_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SZ_W-1:0]   acc_lgsz,
  input  logic              acc_sp_base,
  input  logic              acc_win_cls,
  input  logic              acc_strict,
  input  logic              cfg_align_en,
  input  logic              cfg_sp_align_en,
  input  logic              cfg_unaligned_ok,
  output logic              flt_vld,
  output logic [1:0]        flt_type
);
  localparam int WIN = 1 << WIN_LG;
  localparam logic [1:0] FT_NONE  = 2'b00;
  localparam logic [1:0] FT_ALIGN = 2'b01;
  localparam logic [1:0] FT_SP    = 2'b10;

  logic [SZ_W-1:0]   eff_lg;
  logic [WIN_LG:0]   nbytes;
  logic [WIN_LG-1:0] low;
  logic [WIN_LG+1:0] span;
  logic              elem_mis, sp_mis, win_cross;
  logic              align_flt, sp_flt;
  logic [1:0]        nxt_type;

  assign eff_lg = (acc_lgsz > SZ_W'(WIN_LG)) ? SZ_W'(WIN_LG) : acc_lgsz;
  assign nbytes = (WIN_LG+1)'(1) << eff_lg;
  assign low    = acc_addr[WIN_LG-1:0];
  assign span   = {2'b00, low} + {1'b0, nbytes};

  assign elem_mis  = |({1'b0, low} & (nbytes - (WIN_LG+1)'(1)));
  assign sp_mis    = |low;
  assign win_cross = span > (WIN_LG+2)'(WIN);

  assign align_flt = (elem_mis & (cfg_align_en | acc_strict))
                   | (win_cross & acc_win_cls & ~cfg_unaligned_ok);
  assign sp_flt    = sp_mis & acc_sp_base & cfg_sp_align_en;

  always_comb begin
    nxt_type = FT_NONE;
    if (sp_flt)         nxt_type = FT_SP;
    else if (align_flt) nxt_type = FT_ALIGN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_vld  <= 1'b0;
      flt_type <= FT_NONE;
    end else begin
      flt_vld  <= acc_vld & (nxt_type != FT_NONE);
      flt_type <= acc_vld ? nxt_type : FT_NONE;
    end
  end

  a_r9_no_code_three: assert property (@(posedge clk) disable iff (!rst_n)
    flt_type != 2'b11);
  a_r9_type_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_vld |-> flt_type == FT_NONE);
  a_r9_quiet_without_access: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !flt_vld);
  a_r4_sp_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cfg_sp_align_en && acc_sp_base && acc_addr[WIN_LG-1:0] != '0)
    |=> (flt_vld && flt_type == FT_SP));
  a_r5_sp_off: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !cfg_sp_align_en) |=> flt_type != FT_SP);
  a_r10_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_lgsz == '0 && !acc_sp_base) |=> !flt_vld);
  a_r3_unchecked_class: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !cfg_align_en && !acc_strict && !acc_win_cls && !acc_sp_base) |=> !flt_vld);
endmodule

// File: tb/align_fault_chk_tb.sv
module align_fault_chk_tb;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 48;

  typedef struct {
    logic [1:0] t;
    string      tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_vld = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [2:0]        acc_lgsz = '0;
  logic              acc_sp_base = 1'b0, acc_win_cls = 1'b0, acc_strict = 1'b0;
  logic              cfg_align_en = 1'b0, cfg_sp_align_en = 1'b0, cfg_unaligned_ok = 1'b0;
  logic              flt_vld;
  logic [1:0]        flt_type;

  int   n_chk = 0, n_bad = 0;
  logic sent_q = 1'b0;
  exp_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  align_fault_chk #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .acc_lgsz(acc_lgsz), .acc_sp_base(acc_sp_base), .acc_win_cls(acc_win_cls),
    .acc_strict(acc_strict), .cfg_align_en(cfg_align_en),
    .cfg_sp_align_en(cfg_sp_align_en), .cfg_unaligned_ok(cfg_unaligned_ok),
    .flt_vld(flt_vld), .flt_type(flt_type));

  function automatic logic [1:0] model(logic [ADDR_W-1:0] a, logic [2:0] lg,
                                       logic sp, logic win, logic strict);
    int nb  = 1 << ((lg > 3'd4) ? 4 : int'(lg));
    int off = int'(a[3:0]);
    bit al  = ((cfg_align_en || strict) && (off % nb != 0)) ||
              (win && !cfg_unaligned_ok && (off + nb > 16));
    bit spf = cfg_sp_align_en && sp && (off != 0);
    if (spf) return 2'b10;
    if (al)  return 2'b01;
    return 2'b00;
  endfunction

  task automatic send(logic [ADDR_W-1:0] a, logic [2:0] lg, logic sp, logic win,
                      logic strict, string tag, bit gap = 1'b1);
    exp_t e;
    @(negedge clk);
    acc_vld = 1'b1; acc_addr = a; acc_lgsz = lg;
    acc_sp_base = sp; acc_win_cls = win; acc_strict = strict;
    e.t = model(a, lg, sp, win, strict);
    e.tag = tag;
    sb.push_back(e);
    if (gap) begin
      @(negedge clk);
      acc_vld = 1'b0;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    acc_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic direct(logic [ADDR_W-1:0] a, logic [2:0] lg, logic sp, logic win,
                        logic strict, logic [1:0] want, string tag);
    if (model(a, lg, sp, win, strict) !== want) begin
      n_bad++;
      $display("FAIL %s bench table: actual %b expected %b", tag,
               model(a, lg, sp, win, strict), want);
    end
    send(a, lg, sp, win, strict, tag);
  endtask

  always @(posedge clk) sent_q <= acc_vld;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sent_q) begin
        exp_t e;
        logic       ev;
        e = sb.pop_front();
        ev = (e.t != 2'b00);
        n_chk++;
        if (flt_vld !== ev || flt_type !== e.t) begin
          n_bad++;
          $display("FAIL %s: actual vld=%b type=%b expected vld=%b type=%b",
                   e.tag, flt_vld, flt_type, ev, e.t);
        end
      end else begin
        n_chk++;
        if (flt_vld !== 1'b0 || flt_type !== 2'b00) begin
          n_bad++;
          $display("FAIL R9 idle: actual vld=%b type=%b expected vld=0 type=00",
                   flt_vld, flt_type);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (flt_vld !== 1'b0 || flt_type !== 2'b00) begin
      n_bad++;
      $display("FAIL R11 reset: actual vld=%b type=%b expected vld=0 type=00", flt_vld, flt_type);
    end
    rst_n = 1'b1;
    idle(2);

    cfg_align_en = 1'b1;
    direct(48'h1002, 3'd2, 0, 0, 0, 2'b01, "R1");
    direct(48'h1004, 3'd2, 0, 0, 0, 2'b00, "R1");
    direct(48'h1008, 3'd3, 0, 0, 0, 2'b00, "R1");
    direct(48'h1008, 3'd4, 0, 0, 0, 2'b01, "R10");
    direct(48'h1008, 3'd7, 0, 0, 0, 2'b01, "R10");
    direct(48'h1010, 3'd6, 0, 0, 0, 2'b00, "R10");

    cfg_align_en = 1'b0;
    direct(48'h1003, 3'd1, 0, 0, 0, 2'b00, "R3");
    direct(48'h1003, 3'd1, 0, 0, 1, 2'b01, "R2");

    cfg_sp_align_en = 1'b1;
    direct(48'h2008, 3'd0, 1, 0, 0, 2'b10, "R4");
    direct(48'h2010, 3'd3, 1, 0, 0, 2'b00, "R4");
    direct(48'h2008, 3'd0, 0, 0, 0, 2'b00, "R5");
    cfg_sp_align_en = 1'b0;
    direct(48'h2008, 3'd0, 1, 0, 0, 2'b00, "R5");

    cfg_sp_align_en = 1'b1; cfg_align_en = 1'b1;
    direct(48'h2001, 3'd2, 1, 0, 0, 2'b10, "R8");
    direct(48'h200C, 3'd3, 1, 1, 1, 2'b10, "R8");
    cfg_sp_align_en = 1'b0; cfg_align_en = 1'b0;

    direct(48'h300C, 3'd3, 0, 1, 0, 2'b01, "R6");
    direct(48'h3008, 3'd3, 0, 1, 0, 2'b00, "R6");
    direct(48'h300F, 3'd0, 0, 1, 0, 2'b00, "R6");
    direct(48'h3001, 3'd4, 0, 1, 0, 2'b01, "R6");
    cfg_unaligned_ok = 1'b1;
    direct(48'h300C, 3'd3, 0, 1, 0, 2'b00, "R7");
    direct(48'h3001, 3'd4, 0, 1, 0, 2'b00, "R7");
    cfg_align_en = 1'b1;
    direct(48'h300C, 3'd3, 0, 1, 0, 2'b01, "R1");
    cfg_align_en = 1'b0;

    for (int ok = 0; ok < 2; ok++) begin
      cfg_unaligned_ok = ok[0];
      for (int lg = 0; lg < 5; lg++)
        for (int o = 0; o < 16; o++)
          send(48'h4000 + 48'(o), 3'(lg), 0, 1, 0, ok ? "R7" : "R6", 1'b0);
      idle(1);
    end
    cfg_unaligned_ok = 1'b0;

    cfg_align_en = 1'b1; cfg_sp_align_en = 1'b1;
    for (int i = 0; i < 40; i++)
      send(48'h5000 + 48'(i * 3), 3'(i % 6), i[0], i[1], i[2], "R9", 1'b0);
    idle(3);
    cfg_align_en = 1'b0; cfg_sp_align_en = 1'b0;

    for (int lg = 0; lg < 8; lg++)
      for (int o = 0; o < 16; o++)
        send(48'h6000 + 48'(o), 3'(lg), 0, 0, 1, "R2", 1'b0);
    idle(3);

    summary();
  end
endmodule